// File: doc/BRIEF.md
# Sticky Fault-to-Break Aggregator

This block collects several fault indications from around the chip and merges them into one registered safe-state signal. That signal drives the break inputs of every advanced and general-purpose timer, so a fault forces the PWM outputs into their break state. Four of the five ordinary fault sources are memory double-error flags and a core lockup flag. The fifth is the supply voltage monitor output. Each of the five only takes part once software has armed it through its own bit in a lock register. A clock-failure indication takes part at all times and has no arming bit.

An arming bit can only be set by software. Once set, it stays set until a system reset. A program that has gone astray therefore cannot disarm protection that was put in place at boot. Every fault input, and the clock-failure input, may come from another clock domain, so each passes through a two-flop synchroniser first. The safe-state output comes from a flop, so it cannot glitch.

The register bus is a plain 32-bit write port with a combinational read port, addressed by byte offset.

Top module: `fault_break_unit`

## Requirements
- R1: The lock register sits at byte offset 0x18 and reads back as zero after reset. Each of its five arming bits is set by writing a word with a 1 at that bit's position. The positions are: bit 14 arms faultIn[0] (instruction tightly-coupled memory double error), bit 13 arms faultIn[1] (data tightly-coupled memory double error), bit 6 arms faultIn[2] (core lockup), bit 3 arms faultIn[3] (flash double error) and bit 2 arms faultIn[4] (supply voltage monitor).
- R2: Writing 0 to an arming bit that is set leaves it set. Only assertion of rstN clears an arming bit.
- R3: All lock-register bit positions other than 14, 13, 6, 3 and 2 are reserved. Writes to reserved positions are ignored, and those positions read as 0. A read at any other offset returns 0. A write at any other offset leaves the lock register unchanged.
- R4: safeOut is the OR of each synchronised fault input ANDed with its own arming bit, further ORed with the synchronised clock-failure input.
- R5: clkFailIn forces safeOut high whatever the arming bits hold.
- R6: A change on faultIn or clkFailIn appears on safeOut at the third rising clock edge after the change: two synchroniser stages, then the output flop.
- R7: While rstN is low, safeOut is 0 and the lock register reads 0, even when fault or clock-failure inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| faultIn | input | 5 | Fault indications, one per armable source |
| clkFailIn | input | 1 | Clock-failure indication, never gated |
| safeOut | output | 1 | Registered safe-state request to the timer break inputs |

## Verification
The bench goes through all 32 arming patterns. Under each pattern it applies all 32 fault patterns, with the clock-failure input both low and high. This would catch any source wired to the wrong arming bit, as well as a clock-failure path that was wrongly gated, since either fault gives a wrong output for some combination. Each arming write also sets reserved bits and is followed by clearing writes and by writes to other offsets. A register that was writable, clearable or decoded too loosely would show changed readback. The output is sampled both two and three edges after an input change. A missing or extra synchroniser stage therefore shows up as a timing error. Reset is applied with the inputs held high, which exposes any flop left out of reset.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

  localparam int NUM_SRC = 5;

  typedef struct packed {
    logic lockWr;
    logic lockRd;
  } busStrobe_t;

  function automatic int srcBitPos(input int idx);
    case (idx)
      0:       srcBitPos = 14;
      1:       srcBitPos = 13;
      2:       srcBitPos = 6;
      3:       srcBitPos = 3;
      default: srcBitPos = 2;
    endcase
  endfunction

endpackage

// File: rtl/fbu_sync.sv
module fbu_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/fbu_ctrl.sv
module fbu_ctrl
  import fbu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOCK_OFFSET = 8'h18
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  logic hitLock;

  always_comb begin
    hitLock       = (busAddr == LOCK_OFFSET);
    strobe.lockRd = hitLock;
    strobe.lockWr = hitLock && busWe;
  end

endmodule

// File: rtl/fbu_datapath.sv
module fbu_datapath
  import fbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] faultSync,
  input  logic               clkFailSync,
  output logic [DATA_W-1:0]  rdata,
  output logic               safeOut
);

  logic [NUM_SRC-1:0] lockReg;
  logic [NUM_SRC-1:0] setMask;
  logic [DATA_W-1:0]  lockWord;
  logic [NUM_SRC-1:0] gatedFault;
  logic               safeNext;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
    assign setMask[i] = wdata[srcBitPos(i)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lockReg <= '0;
    else if (strobe.lockWr) lockReg <= lockReg | setMask;
  end

  always_comb begin
    lockWord = '0;
    for (int i = 0; i < NUM_SRC; i++) lockWord[srcBitPos(i)] = lockReg[i];
    rdata = strobe.lockRd ? lockWord : '0;
  end

  always_comb begin
    gatedFault = faultSync & lockReg;
    safeNext   = (|gatedFault) | clkFailSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) safeOut <= 1'b0;
    else       safeOut <= safeNext;
  end

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(lockReg) & ~lockReg) == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R1
    lock_set_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lockReg[i]) |-> $past(strobe.lockWr && wdata[srcBitPos(i)]));
  end

  // R5
  clk_fail_forces_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkFailSync |=> safeOut);

  // R4
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockReg == '0 && !clkFailSync) |=> !safeOut);

endmodule

// File: rtl/fault_break_unit.sv
module fault_break_unit
  import fbu_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LOCK_OFFSET = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [4:0]        faultIn,
  input  logic              clkFailIn,
  output logic              safeOut
);

  localparam int SYNC_W = NUM_SRC + 1;

  busStrobe_t         strobe;
  logic [SYNC_W-1:0]  syncBus;

  fbu_ctrl #(
    .ADDR_W(ADDR_W),
    .LOCK_OFFSET(LOCK_OFFSET)
  ) u_ctrl (
    .busWe(busWe),
    .busAddr(busAddr),
    .strobe(strobe)
  );

  fbu_sync #(
    .WIDTH(SYNC_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({clkFailIn, faultIn}),
    .syncOut(syncBus)
  );

  fbu_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wdata(busWdata),
    .faultSync(syncBus[NUM_SRC-1:0]),
    .clkFailSync(syncBus[NUM_SRC]),
    .rdata(busRdata),
    .safeOut(safeOut)
  );

endmodule

// File: tb/fault_break_unit_test.sv
module fault_break_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOCK_ADDR = 8'h18;
  localparam logic [31:0] JUNK = 32'hA5A5_8003;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  faultIn = '0;
  logic        clkFailIn = 1'b0;
  logic        safeOut;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_break_unit uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .faultIn(faultIn),
    .clkFailIn(clkFailIn), .safeOut(safeOut)
  );

  function automatic logic [31:0] wordOf(input logic [4:0] m);
    int pos [5] = '{14, 13, 6, 3, 2};
    logic [31:0] w = '0;
    for (int i = 0; i < 5; i++) if (m[i]) w[pos[i]] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    step(1);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin
    logic [31:0] rd;
    // R7: reset with all inputs high
    faultIn = '1; clkFailIn = 1'b1;
    step(3);
    busRead(LOCK_ADDR, rd);
    check("R7 lock in reset", rd, 32'h0);
    check("R7 safe in reset", {31'h0, safeOut}, 32'h0);
    faultIn = '0; clkFailIn = 1'b0;
    rstN = 1'b1;
    step(4);
    busRead(LOCK_ADDR, rd);
    check("R1 reset value", rd, 32'h0);

    // R3: other offsets
    busWrite(8'h1C, 32'hFFFF_FFFF);
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(LOCK_ADDR, rd);
    check("R3 foreign write ignored", rd, 32'h0);
    busWrite(LOCK_ADDR, 32'hFFFF_FFFF);
    busRead(LOCK_ADDR, rd);
    check("R3 reserved read zero", rd, 32'h0000_604C);
    busRead(8'h1C, rd);
    check("R3 foreign read zero", rd, 32'h0);

    // R2: sticky, accumulate, reset clears
    doReset();
    busWrite(LOCK_ADDR, wordOf(5'b00101));
    busWrite(LOCK_ADDR, 32'h0);
    busRead(LOCK_ADDR, rd);
    check("R2 zero write no clear", rd, wordOf(5'b00101));
    busWrite(LOCK_ADDR, wordOf(5'b10000));
    busWrite(LOCK_ADDR, ~wordOf(5'b11111));
    busRead(LOCK_ADDR, rd);
    check("R2 accumulate", rd, wordOf(5'b10101));
    for (int k = 0; k < 8; k++) busWrite(8'(k * 4), 32'h0);
    busRead(LOCK_ADDR, rd);
    check("R2 survives write sequence", rd, wordOf(5'b10101));
    doReset();
    busRead(LOCK_ADDR, rd);
    check("R2 reset clears", rd, 32'h0);

    // R6: latency of fault and clock-failure paths
    busWrite(LOCK_ADDR, wordOf(5'b11111));
    step(3);
    faultIn = 5'b00001;
    step(2);
    check("R6 fault not yet", {31'h0, safeOut}, 32'h0);
    step(1);
    check("R6 fault at third edge", {31'h0, safeOut}, 32'h1);
    faultIn = '0;
    step(2);
    check("R6 fall not yet", {31'h0, safeOut}, 32'h1);
    step(1);
    check("R6 fall at third edge", {31'h0, safeOut}, 32'h0);
    clkFailIn = 1'b1;
    step(2);
    check("R6 clkfail not yet", {31'h0, safeOut}, 32'h0);
    step(1);
    check("R6 clkfail at third edge", {31'h0, safeOut}, 32'h1);
    clkFailIn = 1'b0;
    step(3);

    // R1 R3 R4 R5: exhaustive sweep
    for (int m = 0; m < 32; m++) begin
      doReset();
      busWrite(LOCK_ADDR, wordOf(5'(m)) | JUNK);
      busRead(LOCK_ADDR, rd);
      check("R1 arming readback", rd, wordOf(5'(m)));
      for (int f = 0; f < 32; f++) begin
        for (int c = 0; c < 2; c++) begin
          logic expSafe;
          faultIn = 5'(f); clkFailIn = c[0];
          step(3);
          expSafe = ((5'(f) & 5'(m)) != 5'h0) || (c != 0);
          if (c != 0) check("R5 clkfail ungated", {31'h0, safeOut}, {31'h0, expSafe});
          else        check("R4 gated OR", {31'h0, safeOut}, {31'h0, expSafe});
        end
      end
      faultIn = '0; clkFailIn = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule